// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page-to-frame translations. It sits in front of the page table in main memory. A requester presents a virtual page number and the identifier of the running address space. One cycle later the block returns a registered result: a hit flag and, on a hit, the physical frame number. On a miss the requester has to fetch the mapping from the in-memory page table, which costs one extra memory access before the data access. It then writes the mapping back through the fill port.

Each entry stores the identifier of the address space that owns it, so translations from several processes can live side by side. When tagging is turned off with `tag_en` low, identifiers are not compared. In that mode a context-switch pulse empties the whole cache. Requests and results use valid/ready. The request side stalls only while an unconsumed result is held. The fill side refuses a write only in a cycle where the cache is being emptied.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, `rs_valid` is 0 and `lk_ready` is 1, so any lookup misses.
- R2: A lookup accepted at a clock edge (`lk_valid` and `lk_ready` both 1) produces `rs_valid`=1 after that edge. `rs_hit` is 1 when some valid entry holds the requested page and, if `tag_en` is 1, the requested identifier too. `rs_pfn` is then that entry's frame; when several entries qualify, the lowest-numbered one supplies the frame.
- R3: With `tag_en`=1, an entry whose page matches but whose identifier differs gives a miss. Every miss returns `rs_pfn`=0.
- R4: A fill with no existing match is written into the lowest-numbered invalid entry.
- R5: When all entries are valid, a fill with no match replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such replacement only.
- R6: A fill whose page (and identifier, when `tag_en`=1) already sits in a valid entry overwrites the frame of that entry. It does not create a second entry and does not move the round-robin pointer.
- R7: With `tag_en`=0, a high `ctx_sw` at a clock edge invalidates every entry. With `tag_en`=1, `ctx_sw` has no effect.
- R8: In a cycle where `ctx_sw` empties the cache, `fill_ready` is 0 and a presented fill is dropped. Emptying wins over filling. In every other cycle `fill_ready` is 1.
- R9: While `rs_valid`=1 and `rs_ready`=0, the result is held unchanged and `lk_ready` is 0. `lk_ready` is 1 whenever `rs_valid` is 0 or `rs_ready` is 1.
- R10: A lookup and a fill accepted at the same edge see the cache contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_en | input | 1 | 1: compare address-space identifiers; 0: ignore them |
| ctx_sw | input | 1 | Context-switch pulse; empties the cache when `tag_en` is 0 |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_vpn | input | VPN_W | Requested virtual page number |
| lk_asid | input | ASID_W | Requested address-space identifier |
| rs_valid | output | 1 | Lookup result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_hit | output | 1 | 1 on hit, 0 on miss |
| rs_pfn | output | PFN_W | Frame number on hit, 0 on miss |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Owner identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |

## Verification
The bench builds the block with 4 entries, 4-bit page numbers, 6-bit frames and 2-bit identifiers. With these values, every page number against every identifier (64 lookups) can be swept after each change to the cache. The whole cache fills in four writes, so the round-robin pointer wraps within a few fills, and duplicate, tagged and untagged matches are all reachable in a short run. Frames are an arithmetic function of page and identifier, and the bench tracks the expected cache contents itself.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]                  req,
  output logic                          found,
  output logic [((N>1)?$clog2(N):1)-1:0] idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign found = |req;
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N  = 8,
  parameter int VW = 20,
  parameter int AW = 8
) (
  input  logic [N-1:0]    valid,
  input  logic [N*VW-1:0] vpn_flat,
  input  logic [N*AW-1:0] asid_flat,
  input  logic [VW-1:0]   q_vpn,
  input  logic [AW-1:0]   q_asid,
  input  logic            tag_en,
  output logic [N-1:0]    hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic page_eq;
    logic id_eq;
    assign page_eq    = (vpn_flat[g*VW +: VW] == q_vpn);
    assign id_eq      = (asid_flat[g*AW +: AW] == q_asid);
    assign hit_vec[g] = valid[g] && page_eq && (!tag_en || id_eq);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  ent_v,
  input  logic [N-1:0]                  dup_vec,
  input  logic                          req,
  input  logic                          commit,
  output fill_kind_e                    kind,
  output logic [((N>1)?$clog2(N):1)-1:0] wr_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          dup_found;
  logic [IW-1:0] dup_idx;
  logic          free_found;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr_ptr;

  tlb_pick #(.N(N)) i_dup_pick (
    .req   (dup_vec),
    .found (dup_found),
    .idx   (dup_idx)
  );

  tlb_pick #(.N(N)) i_free_pick (
    .req   (~ent_v),
    .found (free_found),
    .idx   (free_idx)
  );

  always_comb begin
    kind   = FILL_NONE;
    wr_idx = rr_ptr;
    if (req) begin
      if (dup_found) begin
        kind   = FILL_UPDATE;
        wr_idx = dup_idx;
      end else if (free_found) begin
        kind   = FILL_FREE;
        wr_idx = free_idx;
      end else begin
        kind   = FILL_EVICT;
        wr_idx = rr_ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (commit && kind == FILL_EVICT) begin
      if (rr_ptr == IW'(N - 1)) rr_ptr <= '0;
      else                      rr_ptr <= rr_ptr + 1'b1;
    end
  end

  a_r4_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    kind == FILL_FREE |-> !ent_v[wr_idx]);

  a_r6_dup_target: assert property (@(posedge clk) disable iff (!rst_n)
    kind == FILL_UPDATE |-> dup_vec[wr_idx]);

  a_r6_rr_still: assert property (@(posedge clk) disable iff (!rst_n)
    commit && kind != FILL_EVICT |=> $stable(rr_ptr));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic              ctx_sw,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [PFN_W-1:0]  rs_pfn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]        ent_v;
  logic [ENTRIES*VPN_W-1:0]  ent_vpn;
  logic [ENTRIES*ASID_W-1:0] ent_asid;
  logic [ENTRIES*PFN_W-1:0]  ent_pfn;

  logic               flush_eff;
  logic               fill_go;
  logic               lk_go;
  logic [ENTRIES-1:0] lk_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic               lk_hit;
  logic [IW-1:0]      lk_idx;
  logic [IW-1:0]      wr_idx;
  fill_kind_e         wr_kind;

  assign flush_eff  = ctx_sw && !tag_en;
  assign fill_ready = !flush_eff;
  assign fill_go    = fill_valid && fill_ready;
  assign lk_ready   = !rs_valid || rs_ready;
  assign lk_go      = lk_valid && lk_ready;

  tlb_match #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) i_lk_match (
    .valid     (ent_v),
    .vpn_flat  (ent_vpn),
    .asid_flat (ent_asid),
    .q_vpn     (lk_vpn),
    .q_asid    (lk_asid),
    .tag_en    (tag_en),
    .hit_vec   (lk_vec)
  );

  tlb_match #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) i_fill_match (
    .valid     (ent_v),
    .vpn_flat  (ent_vpn),
    .asid_flat (ent_asid),
    .q_vpn     (fill_vpn),
    .q_asid    (fill_asid),
    .tag_en    (tag_en),
    .hit_vec   (dup_vec)
  );

  tlb_pick #(.N(ENTRIES)) i_lk_pick (
    .req   (lk_vec),
    .found (lk_hit),
    .idx   (lk_idx)
  );

  tlb_victim #(.N(ENTRIES)) i_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent_v   (ent_v),
    .dup_vec (dup_vec),
    .req     (fill_valid),
    .commit  (fill_go),
    .kind    (wr_kind),
    .wr_idx  (wr_idx)
  );

  // Entry storage: emptying wins over a fill in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_vpn  <= '0;
      ent_asid <= '0;
      ent_pfn  <= '0;
    end else if (flush_eff) begin
      ent_v <= '0;
    end else if (fill_go) begin
      ent_v[wr_idx]                    <= 1'b1;
      ent_vpn[wr_idx*VPN_W +: VPN_W]    <= fill_vpn;
      ent_asid[wr_idx*ASID_W +: ASID_W] <= fill_asid;
      ent_pfn[wr_idx*PFN_W +: PFN_W]    <= fill_pfn;
    end
  end

  // Registered result stage with back-pressure.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_pfn   <= '0;
    end else if (lk_go) begin
      rs_valid <= 1'b1;
      rs_hit   <= lk_hit;
      rs_pfn   <= lk_hit ? ent_pfn[lk_idx*PFN_W +: PFN_W] : '0;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_hit) && $stable(rs_pfn));

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_pfn == '0);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_eff |=> ent_v == '0);

  a_r2_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> ent_v[$past(wr_idx)]);

  a_r1_result_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_go |=> rs_valid);
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int VW = 4;
  localparam int PW = 6;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tag_en = 1'b1;
  logic          ctx_sw = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          rs_valid;
  logic          rs_ready = 1'b1;
  logic          rs_hit;
  logic [PW-1:0] rs_pfn;
  logic          fill_valid = 1'b0;
  logic          fill_ready;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic          m_v    [N];
  logic [VW-1:0] m_vpn  [N];
  logic [AW-1:0] m_asid [N];
  logic [PW-1:0] m_pfn  [N];
  int            m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .ctx_sw(ctx_sw),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_pfn(rs_pfn),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_pfn(fill_pfn)
  );

  function automatic logic [PW-1:0] frame_of(int vpn, int asid, int salt);
    return PW'((vpn * 5 + asid * 3 + salt * 7 + 1) % (1 << PW));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_find(input logic [VW-1:0] v, input logic [AW-1:0] a,
                            output logic hit, output int idx);
    hit = 1'b0;
    idx = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_v[i] && m_vpn[i] == v && (!tag_en || m_asid[i] == a)) begin
        hit = 1'b1;
        idx = i;
      end
    end
  endtask

  task automatic model_fill(logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p);
    logic hit;
    int   idx;
    int   free;
    model_find(v, a, hit, idx);
    if (!hit) begin
      free = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) free = i;
      if (free >= 0) idx = free;
      else begin
        idx  = m_rr;
        m_rr = (m_rr + 1) % N;
      end
    end
    m_v[idx] = 1'b1; m_vpn[idx] = v; m_asid[idx] = a; m_pfn[idx] = p;
  endtask

  // Drive at a falling edge; the cache changes at the next rising edge.
  task automatic do_fill(string req, int v, int a, int salt, logic sw);
    fill_valid = 1'b1;
    fill_vpn   = VW'(v);
    fill_asid  = AW'(a);
    fill_pfn   = frame_of(v, a, salt);
    ctx_sw     = sw;
    #1;
    check(req, 32'(fill_ready), 32'(!(sw && !tag_en)));
    @(negedge clk);
    if (sw && !tag_en) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else begin
      model_fill(VW'(v), AW'(a), frame_of(v, a, salt));
    end
    fill_valid = 1'b0;
    ctx_sw     = 1'b0;
  endtask

  task automatic do_look(string req, int v, int a);
    logic hit;
    int   idx;
    model_find(VW'(v), AW'(a), hit, idx);
    lk_valid = 1'b1;
    lk_vpn   = VW'(v);
    lk_asid  = AW'(a);
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {rs_valid, rs_hit, 24'(rs_pfn)},
          {1'b1, hit, 24'(hit ? m_pfn[idx] : '0)});
  endtask

  task automatic sweep(string req);
    for (int v = 0; v < (1 << VW); v++)
      for (int a = 0; a < (1 << AW); a++)
        do_look(req, v, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
    end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 rs_valid", 32'(rs_valid), 32'd0);
    check("R1 lk_ready", 32'(lk_ready), 32'd1);
    @(negedge clk);
    sweep("R1 empty");

    // Fill free entries in order, all owned by identifier 0.
    for (int v = 0; v < N; v++) do_fill("R4 fill", v, 0, 0, 1'b0);
    sweep("R2 R3 tagged");

    // Full cache: round-robin replacement, then a duplicate overwrite.
    do_fill("R5 evict", 5, 1, 0, 1'b0);
    do_fill("R5 evict", 6, 2, 0, 1'b0);
    do_fill("R6 dup", 2, 0, 3, 1'b0);
    sweep("R5 R6 contents");
    do_fill("R5 R6 wrap", 7, 3, 0, 1'b0);
    do_fill("R5 wrap", 1, 1, 0, 1'b0);
    do_fill("R5 wrap", 8, 2, 0, 1'b0);
    sweep("R5 after wrap");

    // Context switch ignored when tagging is on.
    ctx_sw = 1'b1;
    @(negedge clk);
    ctx_sw = 1'b0;
    sweep("R7 tagged switch");

    // Untagged: identifiers ignored, then emptied by a switch with a fill.
    tag_en = 1'b0;
    sweep("R2 untagged");
    do_fill("R8 flush beats fill", 9, 0, 0, 1'b1);
    sweep("R7 R8 emptied");

    // Lookup and fill at the same edge: old contents answer.
    tag_en = 1'b1;
    lk_valid = 1'b1; lk_vpn = 4'd3; lk_asid = 2'd0;
    fill_valid = 1'b1; fill_vpn = 4'd3; fill_asid = 2'd0; fill_pfn = frame_of(3, 0, 0);
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    model_fill(4'd3, 2'd0, frame_of(3, 0, 0));
    check("R10 same-edge miss", {rs_valid, rs_hit, 24'(rs_pfn)}, {1'b1, 1'b0, 24'd0});
    do_look("R10 later hit", 3, 0);

    // Back-pressure: result held, request stalled.
    do_fill("R9 setup", 4, 1, 0, 1'b0);
    rs_ready = 1'b0;
    do_look("R9 first", 4, 1);
    lk_valid = 1'b1; lk_vpn = 4'd0; lk_asid = 2'd2;
    #1;
    check("R9 lk_ready low", 32'(lk_ready), 32'd0);
    @(negedge clk);
    check("R9 held", {rs_valid, rs_hit, 24'(rs_pfn)}, {1'b1, 1'b1, 24'(frame_of(4, 1, 0))});
    rs_ready = 1'b1;
    #1;
    check("R9 lk_ready high", 32'(lk_ready), 32'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R9 next result", {rs_valid, rs_hit, 24'(rs_pfn)}, {1'b1, 1'b0, 24'd0});
    @(negedge clk);
    check("R9 drained", 32'(rs_valid), 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule